// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches a set of external pins and a separate non-maskable pin, brings each into the module clock through a synchronizer, and decides per channel whether a configured condition has occurred. The six conditions are: nothing, a rising edge, a falling edge, either edge, a high level and a low level. Each channel can put a majority-of-three vote over its last three synchronized samples in front of the detector, which rejects pulses of a single clock cycle.

A detection sets a sticky per-channel flag. Software clears a flag by writing a one to its bit. A detection can also emit a one-cycle event pulse if the channel's event-enable bit is set. While any flagged channel has its wake-enable bit set, the block holds a wake request. The non-maskable channel has its own sense code, its own filter bit and its own flag. No enable mask applies to that channel.

All settings arrive through a single write port. A small run-control state machine has two states. `ST_OFF` is the reset state, in which no detection takes place. `ST_RUN` is the state in which detection runs. The transition `go` (enable bit written as 1) moves from `ST_OFF` to `ST_RUN`. The transition `halt` (enable bit written as 0) and the transition `wipe` (soft reset) return to `ST_OFF`.

Top module: `pinirq_top`

## Requirements
- R1: Edge codes in a channel's 3-bit sense field: 0 never sets the flag, 1 sets it on a rising edge, 2 on a falling edge, 3 on either edge. With the filter off, a pin change set up before rising clock edge 1 shows in the flag after rising edge 3.
- R2: Sense code 4 sets the flag on every cycle the input is high, and sense code 5 on every cycle it is low. A clear written while the level persists therefore leaves the flag at 1.
- R3: With a channel's filter bit set, the detector sees the majority of the last three synchronized samples. A one-cycle pulse then causes no detection, and a change held for two or more cycles is still detected. With the filter bit clear, the same one-cycle pulse is detected.
- R4: Channel i is configured by a 4-bit slot in the word at address 8 + i/8, at bits 4*(i mod 8)+3 down to 4*(i mod 8). Bits 2:0 of the slot hold the sense code and bit 3 is the filter enable.
- R5: Writing address 3 clears every flag whose data bit is 1 and leaves the other flags alone. A detection in the same cycle as a clear wins, so that flag stays at 1. A flag never drops for any other reason except soft reset.
- R6: For a channel whose bit is 1 in the event-enable mask (address 1), each detection produces an event-output pulse in the same cycle the flag is set. A channel whose bit is 0 never pulses.
- R7: wake_req is 1 exactly when some channel has both its flag and its wake-enable bit (address 2) set.
- R8: The non-maskable channel takes its sense code from bits 2:0 and its filter bit from bit 3 of address 4. Writes to address 4 are ignored while the block is in ST_RUN. Writing 1 to bit 0 of address 5 clears its flag, and the flag is otherwise sticky.
- R9: Bit 0 of address 0 is the enable. In ST_OFF no channel detects anything, and flags and events stay as they are or fall. Two cycles after a write of 0 to the enable bit, the event outputs are 0.
- R10: Writing 1 to bit 1 of address 0 returns every register, synchronizer and flag to zero and enters ST_OFF. This happens at that clock edge and takes priority over any other effect of that write.
- R11: After rst_n is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | NUM_CH | External pins, asynchronous |
| nmi_pin | input | 1 | Non-maskable pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| flag | output | NUM_CH | Sticky per-channel detection flags |
| nmi_flag | output | 1 | Sticky non-maskable detection flag |
| evt_out | output | NUM_CH | One-cycle event pulses |
| wake_req | output | 1 | Wake request |

## Verification
The bench looks for the following corner cases and the misbehaviour a wrong design would show:

- **Single-cycle glitch on a filtered channel.** A broken vote would report it.
- **The same glitch on an unfiltered either-edge channel.** This must report. A design that swallows it has a filter stuck on.
- **A clear written while a level condition persists.** The flag must survive. A design that gives the clear priority over the set loses an active level.
- **A write to the non-maskable sense field while running.** A design that accepts it changes the sense mode in service.
- **Latency and slot position, on a channel in the second configuration word.** An off-by-one in the synchronizer depth or in the slot offset shows up as a late flag or a flag on the wrong channel.
- **Long random run with soft resets mixed in.** A cycle-level model checks every flag, event and wake output on every clock. A stale synchronizer after a wipe would produce a spurious edge.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int ADDR_W         = 4;
    localparam int DATA_W         = 32;
    localparam int SLOT_W         = 4;
    localparam int SLOTS_PER_WORD = DATA_W / SLOT_W;

    localparam logic [ADDR_W-1:0] A_CTRL    = 4'd0;
    localparam logic [ADDR_W-1:0] A_EVTEN   = 4'd1;
    localparam logic [ADDR_W-1:0] A_WAKEEN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_FLAGCLR = 4'd3;
    localparam logic [ADDR_W-1:0] A_NMICFG  = 4'd4;
    localparam logic [ADDR_W-1:0] A_NMICLR  = 4'd5;
    localparam int                A_CFGBASE = 8;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_WIPE_BIT = 1;

    typedef enum logic [2:0] {
        SENSE_OFF  = 3'd0,
        SENSE_RISE = 3'd1,
        SENSE_FALL = 3'd2,
        SENSE_BOTH = 3'd3,
        SENSE_HIGH = 3'd4,
        SENSE_LOW  = 3'd5
    } sense_e;

    typedef struct packed {
        logic   filt_en;
        sense_e sense;
    } slot_t;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/pinirq_front.sv
module pinirq_front
    import pinirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic pin,
    input  logic filt_en,
    output logic level
);
    localparam int HIST = 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HIST-1:0]        hist_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
        end else if (soft_clr) begin
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            hist_q <= {hist_q[HIST-2:0], synced};
        end
    end

    always_comb begin
        if (filt_en) level = vote3(synced, hist_q[0], hist_q[1]);
        else         level = synced;
    end

endmodule

// File: rtl/pinirq_sense.sv
module pinirq_sense
    import pinirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   soft_clr,
    input  logic   active,
    input  logic   level,
    input  sense_e sense,
    output logic   det
);
    logic prev_q;
    logic hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        prev_q <= 1'b0;
        else if (soft_clr) prev_q <= 1'b0;
        else               prev_q <= level;
    end

    always_comb begin
        hit = 1'b0;
        case (sense)
            SENSE_RISE: hit = level & ~prev_q;
            SENSE_FALL: hit = ~level & prev_q;
            SENSE_BOTH: hit = level ^ prev_q;
            SENSE_HIGH: hit = level;
            SENSE_LOW:  hit = ~level;
            default:    hit = 1'b0;
        endcase
        det = active & hit;
    end

endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
    import pinirq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     active,
    output logic                     soft_clr,
    output logic [NUM_CH*SLOT_W-1:0] cfg_flat,
    output logic [NUM_CH-1:0]        evt_en,
    output logic [NUM_CH-1:0]        wake_en,
    output logic [NUM_CH-1:0]        flag_clr,
    output slot_t                    nmi_cfg,
    output logic                     nmi_clr
);
    localparam int NUM_WORDS = NUM_CH / SLOTS_PER_WORD;

    run_e state_q, state_d;
    logic ctrl_wr;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign soft_clr = ctrl_wr && wr_data[CTRL_WIPE_BIT];

    // next-state logic: go / halt / wipe
    always_comb begin
        state_d = state_q;
        if (soft_clr) begin
            state_d = ST_OFF;
        end else if (ctrl_wr) begin
            unique case (state_q)
                ST_OFF: if (wr_data[CTRL_EN_BIT])  state_d = ST_RUN;
                ST_RUN: if (!wr_data[CTRL_EN_BIT]) state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // outputs of the run-control machine
    always_comb begin
        unique case (state_q)
            ST_OFF: active = 1'b0;
            ST_RUN: active = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_en  <= '0;
            wake_en <= '0;
            nmi_cfg <= '0;
        end else if (soft_clr) begin
            evt_en  <= '0;
            wake_en <= '0;
            nmi_cfg <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_EVTEN)  evt_en  <= wr_data[NUM_CH-1:0];
            if (wr_addr == A_WAKEEN) wake_en <= wr_data[NUM_CH-1:0];
            if (wr_addr == A_NMICFG && state_q == ST_OFF)
                nmi_cfg <= slot_t'(wr_data[SLOT_W-1:0]);
        end
    end

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(A_CFGBASE + w);
            logic [DATA_W-1:0] word_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                            word_q <= '0;
                else if (soft_clr)                     word_q <= '0;
                else if (wr_en && wr_addr == WADDR)    word_q <= wr_data;
            end
            assign cfg_flat[w*DATA_W +: DATA_W] = word_q;
        end
    endgenerate

    assign flag_clr = (wr_en && wr_addr == A_FLAGCLR) ? wr_data[NUM_CH-1:0] : '0;
    assign nmi_clr  = wr_en && (wr_addr == A_NMICLR) && wr_data[0];

endmodule

// File: rtl/pinirq_top.sv
module pinirq_top
    import pinirq_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pin_in,
    input  logic              nmi_pin,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [NUM_CH-1:0] flag,
    output logic              nmi_flag,
    output logic [NUM_CH-1:0] evt_out,
    output logic              wake_req
);
    logic                     active;
    logic                     soft_clr;
    logic [NUM_CH*SLOT_W-1:0] cfg_flat;
    logic [NUM_CH-1:0]        evt_en;
    logic [NUM_CH-1:0]        wake_en;
    logic [NUM_CH-1:0]        flag_clr;
    slot_t                    nmi_cfg;
    logic                     nmi_clr;
    logic [NUM_CH-1:0]        det;
    logic                     nmi_det;
    logic                     nmi_level;

    pinirq_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .active   (active),
        .soft_clr (soft_clr),
        .cfg_flat (cfg_flat),
        .evt_en   (evt_en),
        .wake_en  (wake_en),
        .flag_clr (flag_clr),
        .nmi_cfg  (nmi_cfg),
        .nmi_clr  (nmi_clr)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            slot_t slot;
            logic  lvl;
            assign slot = slot_t'(cfg_flat[i*SLOT_W +: SLOT_W]);

            pinirq_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_clr (soft_clr),
                .pin      (pin_in[i]),
                .filt_en  (slot.filt_en),
                .level    (lvl)
            );

            pinirq_sense u_sense (
                .clk      (clk),
                .rst_n    (rst_n),
                .soft_clr (soft_clr),
                .active   (active),
                .level    (lvl),
                .sense    (slot.sense),
                .det      (det[i])
            );
        end
    endgenerate

    pinirq_front #(.SYNC_STAGES(SYNC_STAGES)) u_nmi_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .pin      (nmi_pin),
        .filt_en  (nmi_cfg.filt_en),
        .level    (nmi_level)
    );

    pinirq_sense u_nmi_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .active   (active),
        .level    (nmi_level),
        .sense    (nmi_cfg.sense),
        .det      (nmi_det)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag     <= '0;
            nmi_flag <= 1'b0;
            evt_out  <= '0;
        end else if (soft_clr) begin
            flag     <= '0;
            nmi_flag <= 1'b0;
            evt_out  <= '0;
        end else begin
            flag     <= (flag & ~flag_clr) | det;
            nmi_flag <= (nmi_flag & ~nmi_clr) | nmi_det;
            evt_out  <= det & evt_en;
        end
    end

    assign wake_req = |(flag & wake_en);

endmodule

// File: rtl/pinirq_chk.sv
module pinirq_chk
    import pinirq_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [3:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic [NUM_CH-1:0] flag,
    input logic              nmi_flag,
    input logic [NUM_CH-1:0] evt_out,
    input logic              wake_req
);
    logic wipe_wr;
    assign wipe_wr = wr_en && (wr_addr == A_CTRL) && wr_data[CTRL_WIPE_BIT];

    AST_EVT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out & ~flag) == '0); // R6

    AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (flag != '0)); // R7

    AST_WIPE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_wr |=> (flag == '0 && !nmi_flag && evt_out == '0 && !wake_req)); // R10

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_addr == A_FLAGCLR || wipe_wr)) |=> (($past(flag) & ~flag) == '0)); // R5

    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag && !(wr_en && wr_addr == A_NMICLR && wr_data[0]) && !wipe_wr) |=> nmi_flag); // R8

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CTRL && !wr_data[CTRL_EN_BIT]) |=> ##1 (evt_out == '0)); // R9

endmodule

bind pinirq_top pinirq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .flag     (flag),
    .nmi_flag (nmi_flag),
    .evt_out  (evt_out),
    .wake_req (wake_req)
);

// File: tb/sim_pinirq_top.sv
`timescale 1ns/1ps
module sim_pinirq_top;
    localparam int NCH    = 16;
    localparam int PERIOD = 20;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  pin_v = '0;
    logic            nmi_pin = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_addr = '0;
    logic [31:0]     wr_data = '0;
    logic [NCH-1:0]  flag;
    logic            nmi_flag;
    logic [NCH-1:0]  evt_out;
    logic            wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    pinirq_top #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_v), .nmi_pin(nmi_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag(flag), .nmi_flag(nmi_flag), .evt_out(evt_out), .wake_req(wake_req)
    );

    // ---------------- behavioural reference model ----------------
    // index NCH stands for the non-maskable channel
    bit       raw   [NCH+1][4];
    bit       mprev [NCH+1];
    bit       mflag [NCH+1];
    bit       mevt  [NCH];
    bit [3:0] mcfg  [NCH+1];
    bit       men;
    bit [NCH-1:0] mevten, mwake;

    function automatic bit seen(int c);
        bit a = raw[c][1], b = raw[c][2], d = raw[c][3];
        if (mcfg[c][3]) return (a & b) | (a & d) | (b & d);
        return a;
    endfunction

    function automatic bit fires(bit [2:0] s, bit lv, bit pv);
        case (s)
            3'd1: return lv & !pv;
            3'd2: return !lv & pv;
            3'd3: return lv ^ pv;
            3'd4: return lv;
            3'd5: return !lv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_zero();
        for (int c = 0; c <= NCH; c++) begin
            for (int k = 0; k < 4; k++) raw[c][k] = 0;
            mprev[c] = 0; mflag[c] = 0; mcfg[c] = 0;
            if (c < NCH) mevt[c] = 0;
        end
        men = 0; mevten = '0; mwake = '0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_zero();
        end else begin
            bit wipe;
            wipe = wr_en && wr_addr == 4'd0 && wr_data[1];
            for (int c = 0; c <= NCH; c++) begin
                bit lv, d, clr;
                lv = seen(c);
                d = men && fires(mcfg[c][2:0], lv, mprev[c]);
                if (c < NCH) clr = wr_en && wr_addr == 4'd3 && wr_data[c];
                else         clr = wr_en && wr_addr == 4'd5 && wr_data[0];
                mflag[c] = (mflag[c] && !clr) || d;
                if (c < NCH) mevt[c] = d && mevten[c];
                mprev[c] = lv;
                for (int k = 3; k > 0; k--) raw[c][k] = raw[c][k-1];
                raw[c][0] = (c < NCH) ? pin_v[c] : nmi_pin;
            end
            if (wr_en) begin
                case (wr_addr)
                    4'd0: men = wr_data[0];
                    4'd1: mevten = wr_data[NCH-1:0];
                    4'd2: mwake = wr_data[NCH-1:0];
                    4'd4: if (!men) mcfg[NCH] = wr_data[3:0];
                    default:
                        if (wr_addr >= 8 && wr_addr < 8 + NCH/8)
                            for (int k = 0; k < 8; k++)
                                mcfg[(int'(wr_addr) - 8) * 8 + k] = wr_data[4*k +: 4];
                endcase
            end
            if (wipe) model_zero();
        end
    end

    // ---------------- per-clock comparison ----------------
    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [NCH-1:0] ef, ee;
            logic ew;
            ew = 1'b0;
            for (int c = 0; c < NCH; c++) begin
                ef[c] = mflag[c];
                ee[c] = mevt[c];
                ew = ew | (mflag[c] & mwake[c]);
            end
            chk("R1 flags vs model", 32'(flag), 32'(ef));
            chk("R6 events vs model", 32'(evt_out), 32'(ee));
            chk("R7 wake vs model", 32'(wake_req), 32'(ew));
            chk("R8 nmi flag vs model", 32'(nmi_flag), 32'(mflag[NCH]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R11 flags after reset", 32'(flag), 0);
        chk("R11 events after reset", 32'(evt_out), 0);
        chk("R11 nmi/wake after reset", {30'd0, nmi_flag, wake_req}, 0);

        wr(4'd0, 32'h1);
        // ch0 rise, ch1 fall, ch2 both, ch3 high, ch4 low, ch5 both+filt, ch7 rise+filt
        wr(4'd8, 32'h90B5_4321);
        wr(4'd9, 32'h0000_1000);           // ch11 rise, R4
        wr(4'd1, 32'h0000_0801);           // events on ch0, ch11
        wr(4'd2, 32'h0000_0004);           // wake on ch2
        tick(2);

        // R1 latency of a rising edge
        pin_v[0] = 1'b1;
        tick(2);
        chk("R1 flag not yet after two edges", 32'(flag[0]), 0);
        tick(1);
        chk("R1 rising edge flag after third edge", 32'(flag[0]), 1);
        chk("R6 event pulse with flag", 32'(evt_out[0]), 1);
        tick(1);
        chk("R6 event lasts one cycle", 32'(evt_out[0]), 0);

        // R1 falling
        pin_v[1] = 1'b1; tick(5);
        chk("R1 falling mode ignores rise", 32'(flag[1]), 0);
        pin_v[1] = 1'b0; tick(5);
        chk("R1 falling mode sees fall", 32'(flag[1]), 1);

        // R3 glitch
        pin_v[5] = 1'b1; pin_v[2] = 1'b1; tick(1);
        pin_v[5] = 1'b0; pin_v[2] = 1'b0; tick(6);
        chk("R3 filtered glitch rejected", 32'(flag[5]), 0);
        chk("R3 unfiltered glitch seen", 32'(flag[2]), 1);
        chk("R7 wake with flagged wake channel", 32'(wake_req), 1);
        pin_v[7] = 1'b1; tick(6);
        chk("R3 filtered held change accepted", 32'(flag[7]), 1);
        wr(4'd3, 32'h0000_0004);
        chk("R7 wake drops after clear", 32'(wake_req), 0);

        // R2 level
        pin_v[3] = 1'b1; tick(5);
        chk("R2 high level flag", 32'(flag[3]), 1);
        wr(4'd3, 32'h0000_0008);
        chk("R2 clear loses to persisting level", 32'(flag[3]), 1);
        pin_v[3] = 1'b0; tick(5);
        wr(4'd3, 32'h0000_0008);
        chk("R2 clear works after level gone", 32'(flag[3]), 0);

        // R5 write-one-to-clear
        wr(4'd3, 32'h0000_0001);
        chk("R5 cleared bit", 32'(flag[0]), 0);
        chk("R5 other flag untouched", 32'(flag[1]), 1);

        // R4 slot in second word
        pin_v[11] = 1'b1; tick(5);
        chk("R4 second-word slot", 32'(flag[15:8]), 32'h08);

        // R9 disable
        wr(4'd0, 32'h0);
        wr(4'd3, 32'hFFFF);
        pin_v[0] = 1'b0; tick(2); pin_v[0] = 1'b1; pin_v[3] = 1'b1; tick(6);
        chk("R9 nothing detected while off", 32'(flag), 0);
        pin_v[3] = 1'b0;

        // R8 non-maskable channel
        wr(4'd4, 32'h1);
        wr(4'd0, 32'h1);
        wr(4'd4, 32'h4);                   // ignored while running
        nmi_pin = 1'b1; tick(5);
        chk("R8 nmi rising detected", 32'(nmi_flag), 1);
        wr(4'd5, 32'h1);
        chk("R8 sense write ignored while running", 32'(nmi_flag), 0);
        nmi_pin = 1'b0; tick(4);

        // R10 soft reset
        tick(3);
        wr(4'd0, 32'h3);
        chk("R10 flags zero after wipe", 32'(flag), 0);
        chk("R10 nmi/wake zero after wipe", {30'd0, nmi_flag, wake_req}, 0);
        pin_v[0] = 1'b0; tick(2); pin_v[0] = 1'b1; tick(6);
        chk("R10 off and unconfigured after wipe", 32'(flag), 0);

        // random phase against the model
        wr(4'd8, $urandom);
        wr(4'd9, $urandom);
        wr(4'd1, $urandom);
        wr(4'd2, $urandom);
        wr(4'd0, 32'h1);
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            for (int c = 0; c < NCH; c++)
                if ($urandom % 5 == 0) pin_v[c] = ~pin_v[c];
            if ($urandom % 6 == 0) nmi_pin = ~nmi_pin;
            wr_en = 1'b0;
            if ($urandom % 10 == 0) begin
                int pick;
                pick = $urandom % 9;
                wr_en = 1'b1;
                wr_data = $urandom;
                case (pick)
                    0: begin wr_addr = 4'd0; wr_data = ($urandom % 40 == 0) ? 32'h2 : {31'd0, 1'($urandom % 4 != 0)}; end
                    1: wr_addr = 4'd1;
                    2: wr_addr = 4'd2;
                    3, 4: wr_addr = 4'd3;
                    5: wr_addr = 4'd4;
                    6: wr_addr = 4'd5;
                    7: wr_addr = 4'd8;
                    default: wr_addr = 4'd9;
                endcase
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        tick(4);

        done = 1;
        summary();
        $finish;
    end

endmodule